// File: doc/BRIEF.md
# Compare-and-Branch Condition Unit

This block decides one of sixteen comparisons between two 32-bit operands. It keeps no flags from earlier instructions. The second operand is either a register value or a small unsigned immediate that takes the place of a register field. A 4-bit condition code selects the test. The same encoding drives two consumers: a branch decision, and a set-conditionally result that writes exactly 0 or 1 to a register.

Every request is presented for one cycle with `in_valid` high. The decision comes back on registered outputs with `out_valid` one clock later. A branch request drives `taken`. A set request drives `set_result`. The output that the request does not use stays zero. Small negative constants need no sign bit: the two reversed-operand codes compute B<A, so an immediate can sit on either side of a signed or unsigned less-than.

Top module: `cond_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `taken` and `set_result` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Each accepted request produces its result one clock later, and back-to-back requests are allowed.
- R3: Code 0 is true when A equals B. Code 1 is true when A differs from B.
- R4: The signed codes treat the operands as two's complement. Code 2 is A<B, code 3 is A>=B, code 4 is A<=B, code 5 is A>B, and code 14 is B<A.
- R5: The unsigned codes are: code 6 is A<B, code 7 is A>=B, code 8 is A<=B, code 9 is A>B, and code 15 is B<A.
- R6: Code 10 is true when (A AND B) is zero. Code 11 is true when (A AND B) is nonzero.
- R7: Code 12 is always true and code 13 is always false, whatever the operands.
- R8: For a set request (`op_set`=1), `set_result` is 1 when the condition holds and 0 otherwise, with bits 31..1 zero. `taken` is 0.
- R9: For a branch request (`op_set`=0), `taken` equals the condition result and `set_result` is 0.
- R10: With `imm_sel`=1, B is `imm_val` zero-extended to 32 bits (range 0 to 15), and `op_b` has no effect.
- R11: A cycle without `in_valid` yields `out_valid`, `taken` and `set_result` all zero in the next cycle. Results depend only on the current request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| cond | input | 4 | Condition code 0..15 |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Register operand B |
| imm_sel | input | 1 | 1: use immediate as B |
| imm_val | input | 4 | Unsigned immediate for B |
| op_set | input | 1 | 1: set-conditionally, 0: branch |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch decision |
| set_result | output | 32 | Set-conditionally value, 0 or 1 |

## Verification
Every result is due one clock after the cycle in which its request is presented. No result comes out combinationally. The bench drives a request on a falling edge and holds it across one rising edge. It withdraws the request at the next falling edge and samples all three outputs there, half a period after the register loads. Back-to-back requests are sampled the same way, one falling edge after each rising edge. This shows that each result belongs to the request that came immediately before it.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int CBU_DATA_W = 32;
  localparam int CBU_IMM_W  = 4;
  localparam int CBU_COND_W = 4;

  typedef enum logic [CBU_COND_W-1:0] {
    C_EQ    = 4'd0,
    C_NE    = 4'd1,
    C_LT    = 4'd2,
    C_GE    = 4'd3,
    C_LE    = 4'd4,
    C_GT    = 4'd5,
    C_LTU   = 4'd6,
    C_GEU   = 4'd7,
    C_LEU   = 4'd8,
    C_GTU   = 4'd9,
    C_ANDZ  = 4'd10,
    C_ANDNZ = 4'd11,
    C_TRUE  = 4'd12,
    C_FALSE = 4'd13,
    C_RLT   = 4'd14,
    C_RLTU  = 4'd15
  } cbu_cond_e;

endpackage

// File: rtl/cbu_opsel.sv
module cbu_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 4
) (
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] opnd_b
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > IMM_W) begin : g_pad
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_val};
    end else begin : g_trunc
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = imm_sel ? imm_ext : reg_b;
endmodule

// File: rtl/cbu_cmp.sv
module cbu_cmp
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CBU_COND_W-1:0] cond,
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  output logic                  hit,
  output logic                  eq_w,
  output logic                  lt_s_w,
  output logic                  lt_u_w,
  output logic                  gt_s_w,
  output logic                  gt_u_w,
  output logic                  and_zero_w
);
  localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic f_lt_u(input logic [DATA_W-1:0] x,
                                  input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  // signed order = unsigned order after flipping the sign bits
  function automatic logic f_lt_s(input logic [DATA_W-1:0] x,
                                  input logic [DATA_W-1:0] y);
    return f_lt_u(x ^ SIGN_BIT, y ^ SIGN_BIT);
  endfunction

  function automatic logic f_and_zero(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y);
    return (x & y) == '0;
  endfunction

  assign eq_w       = (a == b);
  assign lt_s_w     = f_lt_s(a, b);
  assign lt_u_w     = f_lt_u(a, b);
  assign gt_s_w     = f_lt_s(b, a);
  assign gt_u_w     = f_lt_u(b, a);
  assign and_zero_w = f_and_zero(a, b);

  always_comb begin
    case (cbu_cond_e'(cond))
      C_EQ:    hit = eq_w;
      C_NE:    hit = !eq_w;
      C_LT:    hit = lt_s_w;
      C_GE:    hit = !lt_s_w;
      C_LE:    hit = !gt_s_w;
      C_GT:    hit = gt_s_w;
      C_LTU:   hit = lt_u_w;
      C_GEU:   hit = !lt_u_w;
      C_LEU:   hit = !gt_u_w;
      C_GTU:   hit = gt_u_w;
      C_ANDZ:  hit = and_zero_w;
      C_ANDNZ: hit = !and_zero_w;
      C_TRUE:  hit = 1'b1;
      C_FALSE: hit = 1'b0;
      C_RLT:   hit = gt_s_w;
      C_RLTU:  hit = gt_u_w;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbu_outreg.sv
module cbu_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_set,
  input  logic              hit,
  output logic              out_valid,
  output logic              taken,
  output logic [DATA_W-1:0] set_result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      set_result <= '0;
    end else begin
      out_valid  <= in_valid;
      taken      <= in_valid && !op_set && hit;
      set_result <= {{(DATA_W-1){1'b0}}, in_valid && op_set && hit};
    end
  end
endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import cbu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [CBU_COND_W-1:0] cond,
  input  logic [CBU_DATA_W-1:0] op_a,
  input  logic [CBU_DATA_W-1:0] op_b,
  input  logic                  imm_sel,
  input  logic [CBU_IMM_W-1:0]  imm_val,
  input  logic                  op_set,
  output logic                  out_valid,
  output logic                  taken,
  output logic [CBU_DATA_W-1:0] set_result
);
  logic [CBU_DATA_W-1:0] opnd_b;
  logic                  cmp_hit;
  logic                  eq_w, lt_s_w, lt_u_w, gt_s_w, gt_u_w, and_zero_w;

  cbu_opsel #(.DATA_W(CBU_DATA_W), .IMM_W(CBU_IMM_W)) u_opsel (
    .imm_sel (imm_sel),
    .imm_val (imm_val),
    .reg_b   (op_b),
    .opnd_b  (opnd_b)
  );

  cbu_cmp #(.DATA_W(CBU_DATA_W)) u_cmp (
    .cond       (cond),
    .a          (op_a),
    .b          (opnd_b),
    .hit        (cmp_hit),
    .eq_w       (eq_w),
    .lt_s_w     (lt_s_w),
    .lt_u_w     (lt_u_w),
    .gt_s_w     (gt_s_w),
    .gt_u_w     (gt_u_w),
    .and_zero_w (and_zero_w)
  );

  cbu_outreg #(.DATA_W(CBU_DATA_W)) u_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_set     (op_set),
    .hit        (cmp_hit),
    .out_valid  (out_valid),
    .taken      (taken),
    .set_result (set_result)
  );
endmodule

// File: rtl/cbu_chk.sv
module cbu_chk
  import cbu_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [CBU_COND_W-1:0] cond,
  input logic [CBU_DATA_W-1:0] op_a,
  input logic [CBU_DATA_W-1:0] op_b,
  input logic                  imm_sel,
  input logic [CBU_IMM_W-1:0]  imm_val,
  input logic                  op_set,
  input logic                  out_valid,
  input logic                  taken,
  input logic [CBU_DATA_W-1:0] set_result,
  input logic [CBU_DATA_W-1:0] opnd_b,
  input logic                  cmp_hit
);
  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !taken && set_result == '0));

  a_r8_set_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_set) |=> (!taken && set_result[CBU_DATA_W-1:1] == '0
                              && set_result[0] == $past(cmp_hit)));

  a_r9_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_set) |=> (set_result == '0 && taken == $past(cmp_hit)));

  a_r10_imm_zext: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |-> (opnd_b[CBU_DATA_W-1:CBU_IMM_W] == '0
                 && opnd_b[CBU_IMM_W-1:0] == imm_val));

  a_r7_fixed_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'd12 |-> cmp_hit) and (cond == 4'd13 |-> !cmp_hit));

  a_r3_equal_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_set && !imm_sel && cond == 4'd0 && op_a == op_b) |=> taken);
endmodule

bind cond_unit cbu_chk i_cbu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .cond       (cond),
  .op_a       (op_a),
  .op_b       (op_b),
  .imm_sel    (imm_sel),
  .imm_val    (imm_val),
  .op_set     (op_set),
  .out_valid  (out_valid),
  .taken      (taken),
  .set_result (set_result),
  .opnd_b     (opnd_b),
  .cmp_hit    (cmp_hit)
);

// File: tb/test_cond_unit.sv
`timescale 1ns/1ps
module test_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  cond = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        imm_sel = 1'b0;
  logic [3:0]  imm_val = '0;
  logic        op_set = 1'b0;
  logic        out_valid, taken;
  logic [31:0] set_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  cond_unit i_cond_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
    .op_a(op_a), .op_b(op_b), .imm_sel(imm_sel), .imm_val(imm_val),
    .op_set(op_set), .out_valid(out_valid), .taken(taken),
    .set_result(set_result)
  );

  localparam logic [31:0] MINV = 32'h8000_0000;
  localparam logic [31:0] MAXV = 32'h7FFF_FFFF;

  // {cond, a, b, expected}
  localparam int NV = 25;
  localparam logic [68:0] VEC [NV] = '{
    {4'd0,  32'd5,  32'd5,  1'b1},
    {4'd0,  MINV,   MAXV,   1'b0},
    {4'd1,  MINV,   MAXV,   1'b1},
    {4'd2,  MINV,   MAXV,   1'b1},
    {4'd2,  MAXV,   MINV,   1'b0},
    {4'd3,  MINV,   MAXV,   1'b0},
    {4'd3,  32'd7,  32'd7,  1'b1},
    {4'd4,  32'd7,  32'd7,  1'b1},
    {4'd4,  MAXV,   MINV,   1'b0},
    {4'd5,  MAXV,   MINV,   1'b1},
    {4'd6,  MINV,   MAXV,   1'b0},
    {4'd6,  MAXV,   MINV,   1'b1},
    {4'd7,  MINV,   MAXV,   1'b1},
    {4'd8,  32'd3,  32'd3,  1'b1},
    {4'd8,  MINV,   MAXV,   1'b0},
    {4'd9,  MINV,   MAXV,   1'b1},
    {4'd10, 32'hF0, 32'h0F, 1'b1},
    {4'd10, MINV,   32'hFFFF_FFFF, 1'b0},
    {4'd11, MINV,   32'hFFFF_FFFF, 1'b1},
    {4'd12, 32'd0,  32'd0,  1'b1},
    {4'd13, 32'd0,  32'd0,  1'b0},
    {4'd14, MINV,   MAXV,   1'b0},
    {4'd14, MAXV,   MINV,   1'b1},
    {4'd15, MAXV,   MINV,   1'b0},
    {4'd15, MINV,   MAXV,   1'b1}
  };

  // independent restatement of the condition table
  function automatic bit model(input logic [3:0] c, input logic [31:0] a,
                               input logic [31:0] b);
    int signed sa = a;
    int signed sb = b;
    case (c)
      4'd0:  return a == b;
      4'd1:  return a != b;
      4'd2:  return sa < sb;
      4'd3:  return sa >= sb;
      4'd4:  return sa <= sb;
      4'd5:  return sa > sb;
      4'd6:  return a < b;
      4'd7:  return a >= b;
      4'd8:  return a <= b;
      4'd9:  return a > b;
      4'd10: return (a & b) == 0;
      4'd11: return (a & b) != 0;
      4'd12: return 1'b1;
      4'd13: return 1'b0;
      4'd14: return sb < sa;
      default: return b < a;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4'd1) return "R3";
    if (c <= 4'd5 || c == 4'd14) return "R4";
    if (c <= 4'd9 || c == 4'd15) return "R5";
    if (c <= 4'd11) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request; outputs sampled at the falling edge after the loading edge
  task automatic issue(input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, input bit isel, input logic [3:0] iv,
                       input bit set, input bit exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; cond = c; op_a = a; op_b = b;
    imm_sel = isel; imm_val = iv; op_set = set;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, out_valid}, 64'd1, "out_valid");
    if (set) begin
      check(req, {32'd0, set_result}, {63'd0, exp}, "set_result");
      check("R8", {63'd0, taken}, 64'd0, "taken on set");
    end else begin
      check(req, {63'd0, taken}, {63'd0, exp}, "taken");
      check("R9", {32'd0, set_result}, 64'd0, "set_result on branch");
    end
  endtask

  initial begin : watchdog
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {62'd0, out_valid, taken}, 64'd0, "valid/taken in reset");
    check("R1", {32'd0, set_result}, 64'd0, "set_result in reset");
    in_valid = 1'b1; op_set = 1'b1; cond = 4'd12;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0, "valid held by reset");
    in_valid = 1'b0; op_set = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, out_valid, taken}, 64'd0, "first cycle after reset");

    // table walk, branch and set forms
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][68:65], VEC[i][64:33], VEC[i][32:1], 1'b0, 4'd0, 1'b0,
            VEC[i][0], req_of(VEC[i][68:65]));
      issue(VEC[i][68:65], VEC[i][64:33], VEC[i][32:1], 1'b0, 4'd0, 1'b1,
            VEC[i][0], "R8");
    end

    // all 16 codes against the model on the extreme pairs
    for (int c = 0; c < 16; c++) begin
      issue(4'(c), MINV, MAXV, 1'b0, 4'd0, 1'b0, model(4'(c), MINV, MAXV), req_of(4'(c)));
      issue(4'(c), MAXV, MINV, 1'b0, 4'd0, 1'b1, model(4'(c), MAXV, MINV), req_of(4'(c)));
      issue(4'(c), MINV, 32'd9, 1'b1, 4'd9, 1'b0, model(4'(c), MINV, 32'd9), "R10");
    end

    // R10: immediate replaces op_b, zero-extended
    issue(4'd0, 32'd9, 32'hDEAD_BEEF, 1'b1, 4'd9, 1'b0, 1'b1, "R10");
    issue(4'd6, MINV, 32'hFFFF_FFFF, 1'b1, 4'd15, 1'b0, 1'b0, "R10");
    issue(4'd2, MINV, 32'd0, 1'b1, 4'd15, 1'b1, 1'b1, "R10");
    issue(4'd14, 32'hFFFF_FFFF, 32'd0, 1'b1, 4'd3, 1'b0, 1'b0, "R10");
    issue(4'd15, 32'd2, 32'hFFFF_FFFF, 1'b1, 4'd1, 1'b0, 1'b1, "R10");

    // R2: back-to-back requests
    @(negedge clk);
    in_valid = 1'b1; op_set = 1'b0; imm_sel = 1'b0;
    cond = 4'd12; op_a = '0; op_b = '0;
    @(negedge clk);
    check("R2", {62'd0, out_valid, taken}, 64'd3, "first of pair");
    cond = 4'd13;
    @(negedge clk);
    check("R2", {62'd0, out_valid, taken}, 64'd2, "second of pair");
    in_valid = 1'b0; cond = 4'd12; op_set = 1'b1;

    // R11: idle cycles yield nothing
    @(negedge clk);
    check("R11", {62'd0, out_valid, taken}, 64'd0, "idle valid/taken");
    check("R11", {32'd0, set_result}, 64'd0, "idle set_result");
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0, "second idle");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule